// File: doc/BRIEF.md
# FIFO Flag Offset Programming Controller

This block sets up the two threshold offsets used by the almost-empty and almost-full flags of a 16K-deep, 36-bit synchronous FIFO. The almost-empty offset is called X and the almost-full offset is called Y. The controller reads three flag-select inputs during reset. The value they hold on the last reset cycle picks the mode. In a preset mode both offsets take a fixed constant. In a parallel mode the first two accepted writes on the write port carry the offsets. In the serial mode the offsets are clocked in one bit at a time.

While programming is in progress, the controller keeps writes from reaching the FIFO RAM. In serial mode it also holds the input-ready output low. When programming ends it raises a done output, and from then on writes pass through to the RAM. Offsets outside the legal range of 1 to 16380 are clamped to the nearest limit. A parity-layout output tells the rest of the FIFO whether parity bits are interspersed in the port word.

Top module: `fifo_offset_prog`

## Requirements
- R1: `fsel` (bit 2, bit 1, bit 0) selects a preset as follows: 111 gives 64, 110 gives 16, 101 gives 8, 011 gives 256 and 001 gives 1024. In a preset mode `x_ofs` and `y_ofs` both hold the preset. `prog_done` and `in_ready` go high at the first clock edge after reset is released.
- R2: The mode comes from `fsel` on the last clock edge at which `rst` is high. Later changes of `fsel` have no effect. After `prog_done` rises, `x_ofs` and `y_ofs` stay constant until the next reset.
- R3: In the parallel modes (`fsel` 100 or 000), the first accepted write loads Y and the second loads X. Neither is passed to `ram_wr_en`. `prog_done` rises at the edge of the second write, and the third write is passed through.
- R4: With `fsel` 100 (non-interspersed layout), the offset field is `wr_data[13:0]` and `ilv_parity` is 0.
- R5: With `fsel` 000 (interspersed layout), the offset field is `{wr_data[14:9], wr_data[7:0]}`, `wr_data[8]` is ignored, and `ilv_parity` is 1.
- R6: With `fsel` 010 (serial), one bit of `ser_din` is taken on each edge where `ser_en_n` is low. The 28 bits are Y followed by X, each sent MSB first. Edges with `ser_en_n` high shift nothing.
- R7: In serial mode, `in_ready` and `prog_done` stay low while bits are being taken. Both rise, and the new offsets appear, at the clock edge after the edge that took the 28th bit.
- R8: In both parallel modes, `ser_en_n` and `ser_din` have no effect on the offsets.
- R9: A programmed offset of 0 becomes 1, and one above 16380 becomes 16380.
- R10: While `rst` is high, `prog_done` and `in_ready` are 0. The offsets show the preset in preset modes and 1 in the other modes.
- R11: `ram_wr_en` is high only when `wr_en` is high and `prog_done` is high. A write while `in_ready` is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst | input | 1 | Synchronous active-high master reset |
| fsel | input | 3 | Flag-select inputs, sampled during reset |
| wr_en | input | 1 | Qualified write strobe from the write port |
| wr_data | input | 36 | Write-port data word |
| ser_en_n | input | 1 | Serial shift enable, active low |
| ser_din | input | 1 | Serial offset data |
| x_ofs | output | 14 | Almost-empty offset |
| y_ofs | output | 14 | Almost-full offset |
| ilv_parity | output | 1 | 1 when the interspersed parity layout is selected |
| prog_done | output | 1 | Programming finished, normal operation allowed |
| in_ready | output | 1 | Write port accepts words |
| ram_wr_en | output | 1 | Write strobe passed on to the FIFO RAM |

## Verification
The bench goes after several corner cases. The first is the exact cycle of the first data write in parallel mode: a design that counts steal writes wrongly would forward a Y or X word into the RAM, or swallow the first real data word. The second is the word layout. Bit 8 is set in interspersed-mode words and is a live bit in non-interspersed words, so a design that swaps the layouts or mis-slices the field reports the wrong offset. The third is the serial path, sent with idle gaps that carry inverted data. A design that shifts on idle cycles, reverses the bit order, swaps Y and X, or raises ready one cycle early would show different offsets or timing. The last group covers the clamp limits 0, 16380, 16381 and 16383, and `fsel` toggling on the last reset cycle and after release. These catch a design that fails to saturate or that samples the mode at the wrong time.

// File: rtl/fop_pkg.sv
`timescale 1ns/1ps
package fop_pkg;
  typedef enum logic [1:0] {
    MD_PRESET = 2'd0,
    MD_PAR    = 2'd1,
    MD_SER    = 2'd2
  } fop_mode_e;

  typedef enum logic [2:0] {
    ST_RUN        = 3'd0,
    ST_PAR_Y      = 3'd1,
    ST_PAR_X      = 3'd2,
    ST_SER_SHIFT  = 3'd3,
    ST_SER_COMMIT = 3'd4
  } fop_state_e;
endpackage

// File: rtl/fop_mode_dec.sv
`timescale 1ns/1ps
module fop_mode_dec
  import fop_pkg::*;
#(
  parameter int OFS_W = 14,
  parameter int PRE_111 = 64,
  parameter int PRE_110 = 16,
  parameter int PRE_101 = 8,
  parameter int PRE_011 = 256,
  parameter int PRE_001 = 1024,
  parameter int OFS_MIN = 1
) (
  input  logic [2:0]       fsel,
  output fop_mode_e        mode,
  output logic             ilv,
  output logic [OFS_W-1:0] init_val
);
  always_comb begin
    mode     = MD_PRESET;
    ilv      = 1'b0;
    init_val = OFS_W'(OFS_MIN);
    unique case (fsel)
      3'b111: init_val = OFS_W'(PRE_111);
      3'b110: init_val = OFS_W'(PRE_110);
      3'b101: init_val = OFS_W'(PRE_101);
      3'b011: init_val = OFS_W'(PRE_011);
      3'b001: init_val = OFS_W'(PRE_001);
      3'b010: mode = MD_SER;
      3'b100: mode = MD_PAR;
      default: begin
        mode = MD_PAR;
        ilv  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/fop_ser_shift.sv
`timescale 1ns/1ps
module fop_ser_shift #(
  parameter int BITS = 28
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift_en,
  input  logic            din,
  output logic [BITS-1:0] sh,
  output logic            last
);
  localparam int CW = $clog2(BITS + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sh    <= '0;
    end else if (shift_en) begin
      sh    <= {sh[BITS-2:0], din};
      cnt_q <= (cnt_q == CW'(BITS - 1)) ? '0 : cnt_q + 1'b1;
    end
  end

  assign last = shift_en && (cnt_q == CW'(BITS - 1));
endmodule

// File: rtl/fop_field_sel.sv
`timescale 1ns/1ps
module fop_field_sel #(
  parameter int DATA_W = 36,
  parameter int OFS_W  = 14,
  parameter int SKIP_BIT = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              ilv,
  output logic [OFS_W-1:0]  raw
);
  logic [OFS_W-1:0] flat_f;
  logic [OFS_W-1:0] skip_f;

  assign flat_f = data[OFS_W-1:0];
  assign skip_f = {data[OFS_W:SKIP_BIT+1], data[SKIP_BIT-1:0]};
  assign raw    = ilv ? skip_f : flat_f;
endmodule

// File: rtl/fop_sat.sv
`timescale 1ns/1ps
module fop_sat #(
  parameter int OFS_W   = 14,
  parameter int OFS_MIN = 1,
  parameter int OFS_MAX = 16380
) (
  input  logic [OFS_W-1:0] raw,
  output logic [OFS_W-1:0] val
);
  always_comb begin
    if (raw < OFS_W'(OFS_MIN))      val = OFS_W'(OFS_MIN);
    else if (raw > OFS_W'(OFS_MAX)) val = OFS_W'(OFS_MAX);
    else                            val = raw;
  end
endmodule

// File: rtl/fifo_offset_prog.sv
`timescale 1ns/1ps
module fifo_offset_prog
  import fop_pkg::*;
#(
  parameter int DATA_W  = 36,
  parameter int OFS_W   = 14,
  parameter int OFS_MIN = 1,
  parameter int OFS_MAX = 16380
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        fsel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ser_en_n,
  input  logic              ser_din,
  output logic [OFS_W-1:0]  x_ofs,
  output logic [OFS_W-1:0]  y_ofs,
  output logic              ilv_parity,
  output logic              prog_done,
  output logic              in_ready,
  output logic              ram_wr_en
);
  localparam int SER_BITS = 2 * OFS_W;
  localparam int LANES    = 2;

  fop_state_e       state_q, state_d;
  fop_mode_e        dec_mode;
  logic             dec_ilv;
  logic [OFS_W-1:0] dec_init;
  logic [OFS_W-1:0] par_raw;
  logic [SER_BITS-1:0] ser_word;
  logic             ser_last;
  logic             accept;
  logic [OFS_W-1:0] lane_raw [LANES];
  logic [OFS_W-1:0] lane_sat [LANES];

  fop_mode_dec #(.OFS_W(OFS_W), .OFS_MIN(OFS_MIN)) u_dec (
    .fsel(fsel), .mode(dec_mode), .ilv(dec_ilv), .init_val(dec_init)
  );

  fop_field_sel #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_field (
    .data(wr_data), .ilv(ilv_parity), .raw(par_raw)
  );

  fop_ser_shift #(.BITS(SER_BITS)) u_shift (
    .clk(clk), .rst(rst),
    .shift_en((state_q == ST_SER_SHIFT) && !ser_en_n),
    .din(ser_din), .sh(ser_word), .last(ser_last)
  );

  // Lane 0 carries Y (sent first), lane 1 carries X.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_raw[g] = (state_q == ST_SER_COMMIT)
                       ? ser_word[SER_BITS-1-g*OFS_W -: OFS_W] : par_raw;
    fop_sat #(.OFS_W(OFS_W), .OFS_MIN(OFS_MIN), .OFS_MAX(OFS_MAX)) u_sat (
      .raw(lane_raw[g]), .val(lane_sat[g])
    );
  end

  assign accept = wr_en && in_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PAR_Y:      if (accept) state_d = ST_PAR_X;
      ST_PAR_X:      if (accept) state_d = ST_RUN;
      ST_SER_SHIFT:  if (ser_last) state_d = ST_SER_COMMIT;
      ST_SER_COMMIT: state_d = ST_RUN;
      default:       state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      unique case (dec_mode)
        MD_PAR:  state_q <= ST_PAR_Y;
        MD_SER:  state_q <= ST_SER_SHIFT;
        default: state_q <= ST_RUN;
      endcase
      ilv_parity <= dec_ilv;
      x_ofs      <= dec_init;
      y_ofs      <= dec_init;
      prog_done  <= 1'b0;
      in_ready   <= 1'b0;
    end else begin
      state_q   <= state_d;
      prog_done <= (state_d == ST_RUN);
      in_ready  <= (state_d != ST_SER_SHIFT) && (state_d != ST_SER_COMMIT);
      if ((state_q == ST_PAR_Y && accept) || state_q == ST_SER_COMMIT)
        y_ofs <= lane_sat[0];
      if ((state_q == ST_PAR_X && accept) || state_q == ST_SER_COMMIT)
        x_ofs <= lane_sat[1];
    end
  end

  assign ram_wr_en = wr_en && prog_done;
endmodule

// File: rtl/fop_checker.sv
`timescale 1ns/1ps
module fop_checker #(
  parameter int OFS_W   = 14,
  parameter int OFS_MIN = 1,
  parameter int OFS_MAX = 16380
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [OFS_W-1:0] x_ofs,
  input logic [OFS_W-1:0] y_ofs,
  input logic             ilv_parity,
  input logic             prog_done,
  input logic             in_ready,
  input logic             ram_wr_en
);
  p_ram_gate_r11: assert property (@(posedge clk) disable iff (rst)
    ram_wr_en |-> (wr_en && prog_done));

  p_ready_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    prog_done |-> in_ready);

  p_range_r9: assert property (@(posedge clk) disable iff (rst)
    prog_done |-> (x_ofs >= OFS_W'(OFS_MIN) && x_ofs <= OFS_W'(OFS_MAX) &&
                   y_ofs >= OFS_W'(OFS_MIN) && y_ofs <= OFS_W'(OFS_MAX)));

  p_hold_after_done_r2: assert property (@(posedge clk) disable iff (rst)
    prog_done |=> (prog_done && $stable(x_ofs) && $stable(y_ofs)));

  p_reset_idle_r10: assert property (@(posedge clk)
    rst |=> (!prog_done && !in_ready));

  p_layout_hold_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(ilv_parity));
endmodule

bind fifo_offset_prog fop_checker #(
  .OFS_W(OFS_W), .OFS_MIN(OFS_MIN), .OFS_MAX(OFS_MAX)
) u_fop_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .x_ofs(x_ofs), .y_ofs(y_ofs),
  .ilv_parity(ilv_parity), .prog_done(prog_done), .in_ready(in_ready),
  .ram_wr_en(ram_wr_en)
);

// File: tb/fifo_offset_prog_tb.sv
`timescale 1ns/1ps
module fifo_offset_prog_tb_top;
  localparam int DATA_W = 36;
  localparam int OFS_W  = 14;
  localparam int MAXV   = 16380;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        fsel = 3'b111;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              ser_en_n = 1'b1;
  logic              ser_din = 1'b0;
  logic [OFS_W-1:0]  x_ofs, y_ofs;
  logic              ilv_parity, prog_done, in_ready, ram_wr_en;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fifo_offset_prog dut_i (
    .clk(clk), .rst(rst), .fsel(fsel), .wr_en(wr_en), .wr_data(wr_data),
    .ser_en_n(ser_en_n), .ser_din(ser_din), .x_ofs(x_ofs), .y_ofs(y_ofs),
    .ilv_parity(ilv_parity), .prog_done(prog_done), .in_ready(in_ready),
    .ram_wr_en(ram_wr_en)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int clampv(int v);
    if (v < 1) return 1;
    if (v > MAXV) return MAXV;
    return v;
  endfunction

  function automatic int preset_of(logic [2:0] s);
    case (s)
      3'b111: return 64;
      3'b110: return 16;
      3'b101: return 8;
      3'b011: return 256;
      3'b001: return 1024;
      default: return 1;
    endcase
  endfunction

  // Reset with a wrong select first, the wanted one on the last reset edge,
  // then a different select after release (R2).
  task automatic do_reset(logic [2:0] s);
    @(negedge clk); rst = 1'b1; fsel = ~s;
    @(negedge clk); fsel = s;
    @(negedge clk);
    chk("R10", "done in reset", prog_done, 0);
    chk("R10", "ready in reset", in_ready, 0);
    chk("R10", "x in reset", x_ofs, preset_of(s));
    chk("R10", "y in reset", y_ofs, preset_of(s));
    rst = 1'b0; fsel = ~s;
  endtask

  task automatic run_preset(logic [2:0] s);
    do_reset(s);
    @(negedge clk);
    chk("R1", "preset done", prog_done, 1);
    chk("R1", "preset ready", in_ready, 1);
    chk("R1", "preset x", x_ofs, preset_of(s));
    chk("R1", "preset y", y_ofs, preset_of(s));
    fsel = 3'b010;
    repeat (2) @(negedge clk);
    chk("R2", "x after fsel change", x_ofs, preset_of(s));
    chk("R2", "done after fsel change", prog_done, 1);
  endtask

  function automatic int field_of(logic [DATA_W-1:0] w, bit ip);
    if (ip) return int'(w[14:9]) * 256 + int'(w[7:0]);
    return int'(w[13:0]);
  endfunction

  task automatic run_par(bit ip, logic [DATA_W-1:0] wy, logic [DATA_W-1:0] wx);
    do_reset(ip ? 3'b000 : 3'b100);
    ser_en_n = 1'b0; ser_din = 1'b1;   // serial activity must be ignored (R8)
    @(negedge clk);
    chk(ip ? "R5" : "R4", "layout bit", ilv_parity, ip ? 1 : 0);
    chk("R3", "ready before writes", in_ready, 1);
    chk("R3", "done before writes", prog_done, 0);
    wr_en = 1'b1; wr_data = wy; #1;
    chk("R3", "Y word not forwarded", ram_wr_en, 0);
    @(negedge clk); ser_din = 1'b0; wr_data = wx; #1;
    chk("R3", "X word not forwarded", ram_wr_en, 0);
    chk("R3", "done after Y", prog_done, 0);
    @(negedge clk); wr_data = '1; #1;
    chk("R3", "done after X", prog_done, 1);
    chk("R3", "third write forwarded", ram_wr_en, 1);
    chk(ip ? "R5" : "R4", "y value", y_ofs, clampv(field_of(wy, ip)));
    chk(ip ? "R5" : "R4", "x value", x_ofs, clampv(field_of(wx, ip)));
    @(negedge clk); wr_en = 1'b0; ser_en_n = 1'b1;
    chk("R8", "x unchanged by serial pins", x_ofs, clampv(field_of(wx, ip)));
    chk("R2", "y held", y_ofs, clampv(field_of(wy, ip)));
  endtask

  task automatic run_ser(int yv, int xv, bit gaps);
    logic [2*OFS_W-1:0] word;
    word = {OFS_W'(yv), OFS_W'(xv)};
    do_reset(3'b010);
    for (int i = 2*OFS_W-1; i >= 0; i--) begin
      if (gaps && (i % 5 == 0)) begin
        @(negedge clk); ser_en_n = 1'b1; ser_din = ~word[i];
        wr_en = 1'b1; wr_data = '1; #1;
        chk("R11", "no RAM write while shifting", ram_wr_en, 0);
        chk("R7", "ready low while shifting", in_ready, 0);
        wr_en = 1'b0;
      end
      @(negedge clk); ser_en_n = 1'b0; ser_din = word[i];
    end
    @(negedge clk); ser_en_n = 1'b1; ser_din = 1'b0;
    chk("R7", "ready low after last-bit edge", in_ready, 0);
    chk("R7", "done low after last-bit edge", prog_done, 0);
    @(negedge clk);
    chk("R7", "ready after commit", in_ready, 1);
    chk("R7", "done after commit", prog_done, 1);
    chk("R6", "serial y", y_ofs, clampv(yv));
    chk("R6", "serial x", x_ofs, clampv(xv));
    chk("R9", "serial y clamp", y_ofs, clampv(yv));
  endtask

  initial begin
    logic [2:0] presets [5];
    presets = '{3'b111, 3'b110, 3'b101, 3'b011, 3'b001};
    repeat (3) @(negedge clk);
    for (int i = 0; i < 5; i++) run_preset(presets[i]);

    run_par(1'b0, 36'h0_0000_0000, 36'h0_0000_3FFF);
    run_par(1'b0, 36'h0_0000_0001, 36'h0_0000_3FFC);
    run_par(1'b0, 36'hF_FFFF_FD00, 36'h0_0000_04D2);
    run_par(1'b0, 36'h0_0000_3FFD, 36'h0_0000_0105);
    run_par(1'b1, 36'h0_0000_0100, 36'h0_0000_7EFF);
    run_par(1'b1, 36'h0_0000_1234, 36'h0_0000_0F0F);
    run_par(1'b1, 36'h0_0000_7FFF, 36'h0_0000_0300);
    for (int k = 0; k < 6; k++) begin
      int a = (k * 2749 + 17) % 16384;
      int b = (k * 5153 + 4001) % 16384;
      run_par(k[0], DATA_W'(a * 3 + 256), DATA_W'(b));
    end

    run_ser(16380, 1, 1'b0);
    run_ser(0, 16383, 1'b1);
    run_ser(700, 9999, 1'b1);
    run_ser(16381, 12345, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule